// File: doc/BRIEF.md
# Stop-Clock Gating for CPU and PCI Clock Outputs

This block stops and restarts a group of differential CPU clock pairs and a group of single-ended PCI clock outputs. The rest of the clock generator keeps running while it does so. Two active-low stop pins request the stops. A software run bit is combined with the PCI pin. Per-output configuration bits decide which outputs obey a stop and which keep running. Every signal, including the internal CPU and PCI clock phases, is modelled as a level sampled in one fast clock domain.

A CPU stop parks each affected pair with the true side high and the complement low and undriven. A PCI stop parks each affected lane low. Both stops take effect only at clock-phase boundaries where the output level does not move. No output pulse is ever shortened, and none is lengthened except by the parked state itself.

All pins are plain control or clock-phase levels. No data stream passes through the block, so there is no valid/ready handshake.

Top module: `stop_clk_gate`

## Requirements
- R1: While reset is held and after it is released with no stop requested, every enabled output follows its source phase. All complements are driven (`cpu_c_drv` all ones).
- R2: The CPU stop pin passes through a two-flop synchronizer. A pair parks at the first CPU rising edge after the synchronized request has been seen at two CPU falling edges. If the pin falls during a CPU high phase of at least three fast cycles, exactly two more falling edges appear on `cpu_t`. A parked pair holds `cpu_t`=1 and `cpu_c`=0, with `cpu_c_drv`=0.
- R3: A pair whose `cpu_free_run` bit is 1 keeps toggling while the CPU stop is active. Bit i belongs to pair i.
- R4: After the CPU stop pin is released, a parked pair restarts within two CPU periods (first `cpu_t` fall ≤16 fast cycles with an 8-cycle CPU period). All later high and low pulses have full source width.
- R5: The effective PCI stop is active when `pci_stop_n` is low, or when `sw_pci_run` is low, or both.
- R6: PCI lanes 0 to 5 always obey the effective PCI stop. Lane 6+k obeys it only when `pci_stop_sel[k]` is 1 and otherwise runs freely.
- R7: The effective PCI stop is captured at a PCI rising edge and applied at the following PCI falling edge, so stopped lanes rest low and no high pulse is shortened. After release, a stopped lane runs again within two PCI periods (first high ≤64 fast cycles with a 32-cycle PCI period).
- R8: An output whose enable bit is 0 stays low whatever the stop state: both `cpu_t` and `cpu_c` for a CPU pair, and `pci_out` for a PCI lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_clk_ph | input | 1 | Internal CPU clock phase (true side) |
| pci_clk_ph | input | 1 | Internal PCI clock phase |
| cpu_stop_n | input | 1 | Asynchronous CPU stop request, active low |
| pci_stop_n | input | 1 | Asynchronous PCI stop request, active low |
| sw_pci_run | input | 1 | Software PCI run bit; 0 requests a PCI stop |
| cpu_free_run | input | N_CPU | Per pair: 1 = ignore CPU stop |
| cpu_en | input | N_CPU | Per pair enable; 0 forces both sides low |
| pci_stop_sel | input | N_PCI_CFG | Per configurable lane: 1 = obeys PCI stop |
| pci_en | input | N_PCI_FIXED+N_PCI_CFG | Per lane enable; 0 forces lane low |
| cpu_t | output | N_CPU | Gated true side of each CPU pair |
| cpu_c | output | N_CPU | Gated complement of each CPU pair |
| cpu_c_drv | output | N_CPU | 1 = complement driven, 0 = undriven (parked) |
| pci_out | output | N_PCI_FIXED+N_PCI_CFG | Gated PCI lanes |

## Verification
The assertions assume that each clock phase stays high and stays low for at least two fast cycles. They also assume that the configuration bits and the software run bit do not change in the same cycle as a phase edge of interest. The bench meets both conditions: it derives the CPU phase (8-cycle period) and the PCI phase (32-cycle period) from a counter stepped on the falling edge of the fast clock. It changes stop pins and configuration only on falling fast-clock edges and holds them for many source periods. Latency checks align the stop pins to a known phase, using the counter, so the expected edge counts are fixed.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;

  function automatic edge_t edge_of(input logic prev, input logic cur);
    edge_t e;
    e.rise = ~prev & cur;
    e.fall = prev & ~cur;
    return e;
  endfunction

  function automatic logic [1:0] sat_inc(input logic [1:0] v);
    return (v == 2'd3) ? v : v + 2'd1;
  endfunction
endpackage

// File: rtl/stopclk_sync.sv
module stopclk_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= {STAGES{RST_VAL}};
    else        sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/stopclk_cpu_gate.sv
module stopclk_cpu_gate
  import clkgate_pkg::*;
#(
  parameter int N_PAIR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ph,
  input  logic              stop_req,
  input  logic [N_PAIR-1:0] free_run,
  input  logic [N_PAIR-1:0] en,
  output logic [N_PAIR-1:0] t_out,
  output logic [N_PAIR-1:0] c_out,
  output logic [N_PAIR-1:0] c_drv
);
  logic              ph_d;
  edge_t             e;
  logic              seen1, seen2;
  logic [N_PAIR-1:0] park;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_d <= 1'b0;
    else        ph_d <= ph;
  end

  assign e = edge_of(ph_d, ph);

  // two falling-edge qualification; release clears at once
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen1 <= 1'b0;
      seen2 <= 1'b0;
    end else if (!stop_req) begin
      seen1 <= 1'b0;
      seen2 <= 1'b0;
    end else if (e.fall) begin
      seen1 <= 1'b1;
      seen2 <= seen1;
    end
  end

  for (genvar i = 0; i < N_PAIR; i++) begin : g_pair
    // park state moves only at a rising edge, while the true side is high
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      park[i] <= 1'b0;
      else if (e.rise) park[i] <= seen2 & ~free_run[i];
    end
    assign t_out[i] = en[i] & (ph | park[i]);
    assign c_out[i] = en[i] & ~ph & ~park[i];
    assign c_drv[i] = ~park[i];
  end

  // checking state
  logic [1:0] falls_seen, rel_rises;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      falls_seen <= 2'd0;
      rel_rises  <= 2'd0;
    end else begin
      if (!stop_req)   falls_seen <= 2'd0;
      else if (e.fall) falls_seen <= sat_inc(falls_seen);
      if (stop_req)                 rel_rises <= 2'd0;
      else if (e.rise && (|park))   rel_rises <= sat_inc(rel_rises);
    end
  end

  AST_STOP_TWO_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(park & ~$past(park))) |-> ($past(falls_seen) >= 2'd2)); // R2
  AST_PARK_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(park) |-> ph); // R4
  AST_CPU_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    ((|park) && !stop_req) |-> (rel_rises < 2'd2)); // R4
endmodule

// File: rtl/stopclk_pci_gate.sv
module stopclk_pci_gate
  import clkgate_pkg::*;
#(
  parameter int N_FIX = 6,
  parameter int N_CFG = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ph,
  input  logic                   pin_run,
  input  logic                   sw_run,
  input  logic [N_CFG-1:0]       sel,
  input  logic [N_FIX+N_CFG-1:0] en,
  output logic [N_FIX+N_CFG-1:0] out
);
  localparam int N_LANE = N_FIX + N_CFG;

  logic              ph_d;
  edge_t             e;
  logic              eff_stop, cap;
  logic [N_LANE-1:0] mask, gate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_d <= 1'b0;
    else        ph_d <= ph;
  end

  assign e        = edge_of(ph_d, ph);
  assign eff_stop = ~pin_run | ~sw_run;
  assign mask     = {sel, {N_FIX{1'b1}}};

  // sampled once per PCI cycle at the rising boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap <= 1'b0;
    else if (e.rise) cap <= eff_stop;
  end

  for (genvar j = 0; j < N_LANE; j++) begin : g_lane
    // gate moves only at a falling boundary, while the lane is low
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      gate[j] <= 1'b0;
      else if (e.fall) gate[j] <= cap & mask[j];
    end
    assign out[j] = en[j] & ph & ~gate[j];
  end

  logic [1:0] rel_rises;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 rel_rises <= 2'd0;
    else if (eff_stop)          rel_rises <= 2'd0;
    else if (e.rise && (|gate)) rel_rises <= sat_inc(rel_rises);
  end

  AST_GATE_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gate) |-> !ph); // R7
  AST_PCI_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gate) && !eff_stop) |-> (rel_rises < 2'd2)); // R7
endmodule

// File: rtl/stop_clk_gate.sv
module stop_clk_gate #(
  parameter int N_CPU       = 2,
  parameter int N_PCI_FIXED = 6,
  parameter int N_PCI_CFG   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cpu_clk_ph,
  input  logic                               pci_clk_ph,
  input  logic                               cpu_stop_n,
  input  logic                               pci_stop_n,
  input  logic                               sw_pci_run,
  input  logic [N_CPU-1:0]                   cpu_free_run,
  input  logic [N_CPU-1:0]                   cpu_en,
  input  logic [N_PCI_CFG-1:0]               pci_stop_sel,
  input  logic [N_PCI_FIXED+N_PCI_CFG-1:0]   pci_en,
  output logic [N_CPU-1:0]                   cpu_t,
  output logic [N_CPU-1:0]                   cpu_c,
  output logic [N_CPU-1:0]                   cpu_c_drv,
  output logic [N_PCI_FIXED+N_PCI_CFG-1:0]   pci_out
);
  logic cpu_run_s, pci_run_s;

  stopclk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_cpu_sync (
    .clk(clk), .rst_n(rst_n), .d(cpu_stop_n), .q(cpu_run_s));

  stopclk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_pci_sync (
    .clk(clk), .rst_n(rst_n), .d(pci_stop_n), .q(pci_run_s));

  stopclk_cpu_gate #(.N_PAIR(N_CPU)) i_cpu_gate (
    .clk(clk), .rst_n(rst_n), .ph(cpu_clk_ph), .stop_req(~cpu_run_s),
    .free_run(cpu_free_run), .en(cpu_en),
    .t_out(cpu_t), .c_out(cpu_c), .c_drv(cpu_c_drv));

  stopclk_pci_gate #(.N_FIX(N_PCI_FIXED), .N_CFG(N_PCI_CFG)) i_pci_gate (
    .clk(clk), .rst_n(rst_n), .ph(pci_clk_ph), .pin_run(pci_run_s),
    .sw_run(sw_pci_run), .sel(pci_stop_sel), .en(pci_en), .out(pci_out));

  for (genvar i = 0; i < N_CPU; i++) begin : g_chk
    AST_UNDRIVEN_PARKED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_en[i] && !cpu_c_drv[i]) |-> (cpu_t[i] && !cpu_c[i])); // R2
  end
endmodule

// File: tb/test_stop_clk_gate.sv
module test_stop_clk_gate;
  localparam int NC = 2;
  localparam int NP = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [7:0] ph_cnt = 8'd0;
  always @(negedge clk) ph_cnt <= ph_cnt + 8'd1;

  logic cpu_clk_ph, pci_clk_ph;
  assign cpu_clk_ph = ph_cnt[2];
  assign pci_clk_ph = ph_cnt[4];

  logic          cpu_stop_n = 1'b1, pci_stop_n = 1'b1, sw_pci_run = 1'b1;
  logic [NC-1:0] cpu_free_run = '0, cpu_en = '1;
  logic [2:0]    pci_stop_sel = 3'b111;
  logic [NP-1:0] pci_en = '1;
  logic [NC-1:0] cpu_t, cpu_c, cpu_c_drv;
  logic [NP-1:0] pci_out;

  stop_clk_gate i_stop_clk_gate (
    .clk(clk), .rst_n(rst_n), .cpu_clk_ph(cpu_clk_ph), .pci_clk_ph(pci_clk_ph),
    .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .sw_pci_run(sw_pci_run),
    .cpu_free_run(cpu_free_run), .cpu_en(cpu_en), .pci_stop_sel(pci_stop_sel),
    .pci_en(pci_en), .cpu_t(cpu_t), .cpu_c(cpu_c), .cpu_c_drv(cpu_c_drv),
    .pci_out(pci_out));

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  // {cpu_n, pci_n, sw, free[1:0], sel[2:0], exp_park[1:0], exp_stop[8:0]}
  localparam logic [18:0] VEC [8] = '{
    {1'b1, 1'b1, 1'b1, 2'b00, 3'b111, 2'b00, 9'h000},
    {1'b0, 1'b1, 1'b1, 2'b00, 3'b111, 2'b11, 9'h000},
    {1'b0, 1'b1, 1'b1, 2'b01, 3'b111, 2'b10, 9'h000},
    {1'b0, 1'b1, 1'b1, 2'b10, 3'b111, 2'b01, 9'h000},
    {1'b1, 1'b0, 1'b1, 2'b00, 3'b111, 2'b00, 9'h1FF},
    {1'b1, 1'b1, 1'b0, 2'b00, 3'b000, 2'b00, 9'h03F},
    {1'b1, 1'b0, 1'b0, 2'b00, 3'b101, 2'b00, 9'h17F},
    {1'b0, 1'b1, 1'b1, 2'b11, 3'b000, 2'b00, 9'h000}
  };

  task automatic observe(input int n,
      output logic [NC-1:0] t_or, t_and, c_or, drv_or, drv_and,
      output logic [NP-1:0] p_or, p_and);
    t_or = '0; t_and = '1; c_or = '0; drv_or = '0; drv_and = '1;
    p_or = '0; p_and = '1;
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      t_or = t_or | cpu_t;  t_and = t_and & cpu_t;
      c_or = c_or | cpu_c;
      drv_or = drv_or | cpu_c_drv; drv_and = drv_and & cpu_c_drv;
      p_or = p_or | pci_out; p_and = p_and & pci_out;
    end
  endtask

  function automatic logic pick(input int w);
    if (w < 2)      return cpu_t[w];
    else if (w < 4) return cpu_c[w-2];
    else            return pci_out[w-4];
  endfunction

  task automatic watch(input int w, input int n, output int falls,
                       output int first_hi, output int first_fall,
                       output int min_hi, output int min_lo, output logic last);
    logic lvl, cur;
    int run;
    bit first_run;
    @(posedge clk); #1;
    lvl = pick(w); run = 1; first_run = 1; falls = 0;
    first_hi = lvl ? 0 : -1; first_fall = -1; min_hi = 999; min_lo = 999;
    for (int k = 1; k < n; k++) begin
      @(posedge clk); #1;
      cur = pick(w);
      if (cur && first_hi < 0) first_hi = k;
      if (cur != lvl) begin
        if (!first_run) begin
          if (lvl && run < min_hi) min_hi = run;
          if (!lvl && run < min_lo) min_lo = run;
        end
        if (lvl) begin
          falls++;
          if (first_fall < 0) first_fall = k;
        end
        first_run = 0; run = 1; lvl = cur;
      end else run++;
    end
    last = lvl;
  endtask

  task automatic align(input bit cpu_side);
    if (cpu_side) do @(posedge clk); while (ph_cnt[2:0] != 3'd4);
    else          do @(posedge clk); while (ph_cnt[4:0] != 5'd16);
    @(negedge clk);
  endtask

  initial begin
    logic [NC-1:0] t_or, t_and, c_or, drv_or, drv_and;
    logic [NP-1:0] p_or, p_and;
    int falls, fh, ff, mh, ml;
    logic last;

    // R1: reset state
    observe(40, t_or, t_and, c_or, drv_or, drv_and, p_or, p_and);
    check(drv_and == 2'b11, "R1", "complement driven in reset", drv_and, 3);
    check(t_or == 2'b11 && t_and == 2'b00, "R1", "cpu toggles in reset", t_or, 3);
    check(p_or == '1 && p_and == '0, "R1", "pci toggles in reset", p_or, 9'h1FF);
    @(negedge clk); rst_n = 1'b1;

    // table walk: R2 R3 R5 R6
    for (int v = 0; v < 8; v++) begin
      logic [1:0] ep;
      logic [8:0] es;
      @(negedge clk);
      {cpu_stop_n, pci_stop_n, sw_pci_run, cpu_free_run, pci_stop_sel} = VEC[v][18:11];
      ep = VEC[v][10:9];
      es = VEC[v][8:0];
      repeat (128) @(posedge clk);
      observe(64, t_or, t_and, c_or, drv_or, drv_and, p_or, p_and);
      check(t_and == ep && (c_or & ep) == '0 && (drv_or & ep) == '0 &&
            (t_or & ~ep) == ~ep && (t_and & ~ep) == '0 && (drv_and & ~ep) == ~ep,
            "R2/R3", $sformatf("cpu vector %0d park", v), t_and, ep);
      check((p_or & es) == '0 && (p_or & ~es) == ~es && p_and == '0,
            "R5/R6", $sformatf("pci vector %0d stop", v), p_or, ~es);
    end

    // R2: exact two falls then park high
    @(negedge clk); cpu_stop_n = 1'b1; cpu_free_run = '0;
    repeat (64) @(posedge clk);
    align(1'b1); cpu_stop_n = 1'b0;
    watch(0, 48, falls, fh, ff, mh, ml, last);
    check(falls == 2, "R2", "cpu_t falls before park", falls, 2);
    check(last == 1'b1 && cpu_c[0] == 1'b0 && cpu_c_drv[0] == 1'b0,
          "R2", "parked level t/c/drv", {last, cpu_c[0], cpu_c_drv[0]}, 3'b100);

    // R4: restart latency and full-width pulses
    align(1'b1); cpu_stop_n = 1'b1;
    watch(0, 40, falls, fh, ff, mh, ml, last);
    check(ff >= 0 && ff <= 16, "R4", "first fall after release", ff, 16);
    check(mh == 4 && ml == 4, "R4", "pulse widths after release", mh * 16 + ml, 68);

    // R7: stop applied in low phase, full last pulse, restart latency
    align(1'b0); pci_stop_n = 1'b0;
    watch(4, 96, falls, fh, ff, mh, ml, last);
    check(mh == 16 && last == 1'b0, "R7", "stop last pulse/level", mh, 16);
    align(1'b0); pci_stop_n = 1'b1;
    watch(4, 96, falls, fh, ff, mh, ml, last);
    check(fh >= 0 && fh <= 64 && mh == 16, "R7", "restart latency", fh, 64);

    // R8: enables force low
    @(negedge clk); cpu_en = 2'b10; pci_en = 9'h17F; cpu_free_run = 2'b01;
    repeat (64) @(posedge clk);
    observe(64, t_or, t_and, c_or, drv_or, drv_and, p_or, p_and);
    check(t_or == 2'b10 && c_or == 2'b10, "R8", "cpu pair0 disabled low", {t_or, c_or}, 4'b1010);
    check(p_or == 9'h17F, "R8", "pci lane7 disabled low", p_or, 9'h17F);
    @(negedge clk); cpu_stop_n = 1'b0; cpu_free_run = '0;
    repeat (64) @(posedge clk);
    observe(32, t_or, t_and, c_or, drv_or, drv_and, p_or, p_and);
    check(t_or[0] == 1'b0 && c_or[0] == 1'b0 && t_and[1] == 1'b1, "R8",
          "disabled pair low under stop", {t_or[0], c_or[0], t_and[1]}, 3'b001);

    summary();
  end
endmodule